// File: doc/BRIEF.md
# Valiant Two-Phase Route Computation

This block computes the next hop for a packet in a two-dimensional mesh router that spreads traffic with an oblivious two-phase detour. When a packet enters the network from the local port, the block draws an intermediate node from a free-running pseudo-random generator. The packet first heads for that node and then, in its second phase, for its real destination. Each leg fully corrects the X offset before it touches the Y offset, so each leg follows dimension order.

Two options shape the detour. With quadrant mode set, the intermediate node is drawn from the same half of the mesh as the destination, on each axis. With load gating set, the detour is taken only while the high-load input is asserted. Otherwise the packet is sent on the minimal dimension-order path straight to its destination. Each cycle the block accepts one header together with the router's own coordinates. One cycle later it presents the chosen output port as a one-hot vector, along with the updated header: destination, intermediate node and phase bit. Switch allocation and buffering are left to the surrounding router.

Top module: `valiant_route`

## Requirements
- R1: Every accepted header (`in_valid` high at a clock edge) produces `out_valid` high on the next edge, with the port and header computed from that cycle's inputs. A cycle with `in_valid` low produces `out_valid` low on the next edge.
- R2: The generator is a 16-bit shift register with seed 0xACE1. It shifts left by one on every clock edge out of reset, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. At an injection (`in_inject` high) without any option active, the intermediate X is bits [7:0] modulo MESH_X and the intermediate Y is bits [15:8] modulo MESH_Y. Both use the register value held at the accepting edge, and the output phase starts at 0.
- R3: In quadrant mode, on each axis with size S and half H = S/2: a destination coordinate below H gives (random byte mod H). Any other destination coordinate gives H + (random byte mod (S - H)). The X axis uses bits [7:0] and the Y axis uses bits [15:8].
- R4: With `gate_mode` high and `high_load` low at an injection, the intermediate is set equal to the destination and the phase is 1. With `high_load` high, the random detour of R2 or R3 applies.
- R5: A phase-0 packet whose intermediate equals the router coordinates leaves with phase 1 and is routed toward its destination. This includes an injection whose drawn intermediate equals the source.
- R6: For a packet that is not injecting, the intermediate and destination pass through unchanged, and a phase of 1 stays 1.
- R7: The target is the intermediate in phase 0 and the destination in phase 1. The port is east if target X > current X, and west if it is smaller. Otherwise it is north if target Y > current Y, south if it is smaller, and local if both are equal. The one-hot port bits are local=0, north=1, east=2, south=3, west=4.
- R8: A phase-1 packet at its destination coordinates is sent to the local port.
- R9: While reset is low at a clock edge, all outputs go to zero on that edge.
- R10: When `out_valid` is low, `out_port` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Header present this cycle |
| in_inject | input | 1 | Packet is entering from the local port here |
| in_dst_x | input | XW | Destination X |
| in_dst_y | input | YW | Destination Y |
| in_mid_x | input | XW | Intermediate X carried in the header (ignored on injection) |
| in_mid_y | input | YW | Intermediate Y carried in the header (ignored on injection) |
| in_phase | input | 1 | Header phase, 0 = toward intermediate (ignored on injection) |
| cur_x | input | XW | This router's X coordinate |
| cur_y | input | YW | This router's Y coordinate |
| quad_mode | input | 1 | Restrict intermediate to the destination's half on each axis |
| gate_mode | input | 1 | Detour only under high load |
| high_load | input | 1 | Network load indication |
| out_valid | output | 1 | Result valid |
| out_port | output | 5 | One-hot output port |
| out_dst_x | output | XW | Destination X |
| out_dst_y | output | YW | Destination Y |
| out_mid_x | output | XW | Intermediate X |
| out_mid_y | output | YW | Intermediate Y |
| out_phase | output | 1 | Updated phase |

## Verification
Every result is due exactly one clock edge after the header is presented: port, header and valid all come from a single register stage. The generator value used for an injection is the one held at that same accepting edge. The bench drives a header on a falling edge and records the expected result from its own generator model and route rules. On the next falling edge, after the single intervening rising edge, it compares the outputs against that record. This keeps each check aligned with the one-register delay, and the generator model stays in step because it advances on the same rising edges as the design.

// File: rtl/vrc_pkg.sv
// Shared constants for the two-phase route computation.
// Assumes a five-port mesh router with one-hot port vectors.
package vrc_pkg;
    localparam int NPORT     = 5;
    localparam int P_LOCAL   = 0;
    localparam int P_NORTH   = 1;
    localparam int P_EAST    = 2;
    localparam int P_SOUTH   = 3;
    localparam int P_WEST    = 4;
    localparam int RND_W     = 16;
    localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
endpackage

// File: rtl/vrc_lfsr.sv
// Free-running shift-register pseudo-random source.
// Shifts left every cycle out of reset; feedback is the XOR of the tap mask.
module vrc_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state
);
    // Advance the sequence by one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[WIDTH-2:0], ^(state & TAPS)};
    end
endmodule

// File: rtl/vrc_axis_pick.sv
// Picks one intermediate coordinate on one mesh axis from a random byte.
// Assumes SIZE >= 2; quadrant mode keeps the pick in the destination's half.
module vrc_axis_pick #(
    parameter int SIZE = 8,
    parameter int W    = $clog2(SIZE)
) (
    input  logic [7:0]   rnd,
    input  logic [W-1:0] dst,
    input  logic         quad,
    output logic [W-1:0] pick
);
    localparam int         HALF = SIZE / 2;
    localparam logic [7:0] SZ8  = 8'(SIZE);
    localparam logic [7:0] LO8  = 8'(HALF);
    localparam logic [7:0] HI8  = 8'(SIZE - HALF);

    logic [7:0] full_m;
    logic [7:0] lo_m;
    logic [7:0] hi_m;

    // Reduce the random byte into the full axis or one of its halves.
    always_comb begin
        full_m = rnd % SZ8;
        lo_m   = rnd % LO8;
        hi_m   = LO8 + (rnd % HI8);
        if (!quad)                pick = W'(full_m);
        else if (dst < W'(HALF))  pick = W'(lo_m);
        else                      pick = W'(hi_m);
    end
endmodule

// File: rtl/vrc_dor_port.sv
// Phase update and dimension-order port choice for one header.
// Assumes coordinates are within the mesh; X is corrected before Y.
module vrc_dor_port
    import vrc_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    input  logic [XW-1:0]    mid_x,
    input  logic [YW-1:0]    mid_y,
    input  logic [XW-1:0]    dst_x,
    input  logic [YW-1:0]    dst_y,
    input  logic             phase_in,
    output logic             phase_out,
    output logic [NPORT-1:0] port
);
    logic [XW-1:0] tgt_x;
    logic [YW-1:0] tgt_y;

    // Flip to phase 1 at the intermediate, then steer X first, then Y.
    always_comb begin
        phase_out = phase_in | ((cur_x == mid_x) && (cur_y == mid_y));
        tgt_x     = phase_out ? dst_x : mid_x;
        tgt_y     = phase_out ? dst_y : mid_y;
        port      = '0;
        if (tgt_x > cur_x)      port[P_EAST]  = 1'b1;
        else if (tgt_x < cur_x) port[P_WEST]  = 1'b1;
        else if (tgt_y > cur_y) port[P_NORTH] = 1'b1;
        else if (tgt_y < cur_y) port[P_SOUTH] = 1'b1;
        else                    port[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/valiant_route.sv
// Two-phase oblivious route computation for a 2D mesh router.
// Draws an intermediate node at injection, tracks the phase bit and picks
// the output port; one register stage from header to result.
module valiant_route
    import vrc_pkg::*;
#(
    parameter int MESH_X = 8,
    parameter int MESH_Y = 8,
    localparam int XW = $clog2(MESH_X),
    localparam int YW = $clog2(MESH_Y)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_inject,
    input  logic [XW-1:0]    in_dst_x,
    input  logic [YW-1:0]    in_dst_y,
    input  logic [XW-1:0]    in_mid_x,
    input  logic [YW-1:0]    in_mid_y,
    input  logic             in_phase,
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    input  logic             quad_mode,
    input  logic             gate_mode,
    input  logic             high_load,
    output logic             out_valid,
    output logic [4:0]       out_port,
    output logic [XW-1:0]    out_dst_x,
    output logic [YW-1:0]    out_dst_y,
    output logic [XW-1:0]    out_mid_x,
    output logic [YW-1:0]    out_mid_y,
    output logic             out_phase
);
    logic [RND_W-1:0] rnd;
    logic [XW-1:0]    pick_x;
    logic [YW-1:0]    pick_y;
    logic             detour;
    logic [XW-1:0]    sel_mid_x;
    logic [YW-1:0]    sel_mid_y;
    logic             sel_phase;
    logic             nxt_phase;
    logic [NPORT-1:0] nxt_port;

    vrc_lfsr #(.WIDTH(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    vrc_axis_pick #(.SIZE(MESH_X), .W(XW)) u_pick_x (
        .rnd  (rnd[7:0]),
        .dst  (in_dst_x),
        .quad (quad_mode),
        .pick (pick_x)
    );

    vrc_axis_pick #(.SIZE(MESH_Y), .W(YW)) u_pick_y (
        .rnd  (rnd[15:8]),
        .dst  (in_dst_y),
        .quad (quad_mode),
        .pick (pick_y)
    );

    // Choose the header's intermediate and starting phase.
    always_comb begin
        detour = !(gate_mode && !high_load);
        if (in_inject) begin
            sel_mid_x = detour ? pick_x : in_dst_x;
            sel_mid_y = detour ? pick_y : in_dst_y;
            sel_phase = !detour;
        end else begin
            sel_mid_x = in_mid_x;
            sel_mid_y = in_mid_y;
            sel_phase = in_phase;
        end
    end

    vrc_dor_port #(.XW(XW), .YW(YW)) u_dor (
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .mid_x     (sel_mid_x),
        .mid_y     (sel_mid_y),
        .dst_x     (in_dst_x),
        .dst_y     (in_dst_y),
        .phase_in  (sel_phase),
        .phase_out (nxt_phase),
        .port      (nxt_port)
    );

    // Register the result one cycle after the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_dst_x <= '0;
            out_dst_y <= '0;
            out_mid_x <= '0;
            out_mid_y <= '0;
            out_phase <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_port  <= in_valid ? nxt_port : '0;
            if (in_valid) begin
                out_dst_x <= in_dst_x;
                out_dst_y <= in_dst_y;
                out_mid_x <= sel_mid_x;
                out_mid_y <= sel_mid_y;
                out_phase <= nxt_phase;
            end
        end
    end
endmodule

// File: rtl/valiant_route_chk.sv
// Temporal checks for the route computation, attached by bind.
module valiant_route_chk #(
    parameter int MESH_X = 8,
    parameter int MESH_Y = 8,
    parameter int XW = 3,
    parameter int YW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_inject,
    input logic [XW-1:0] in_dst_x,
    input logic [YW-1:0] in_dst_y,
    input logic [XW-1:0] in_mid_x,
    input logic [YW-1:0] in_mid_y,
    input logic          in_phase,
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y,
    input logic          quad_mode,
    input logic          gate_mode,
    input logic          high_load,
    input logic          out_valid,
    input logic [4:0]    out_port,
    input logic [XW-1:0] out_dst_x,
    input logic [YW-1:0] out_dst_y,
    input logic [XW-1:0] out_mid_x,
    input logic [YW-1:0] out_mid_y,
    input logic          out_phase
);
    localparam logic [XW-1:0] HX = XW'(MESH_X / 2);
    localparam logic [YW-1:0] HY = YW'(MESH_Y / 2);

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_quad_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_inject && quad_mode && !(gate_mode && !high_load)) |=>
        (((out_mid_x < HX) == (out_dst_x < HX)) && ((out_mid_y < HY) == (out_dst_y < HY))));
    p_gate_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_inject && gate_mode && !high_load) |=>
        (out_phase && out_mid_x == out_dst_x && out_mid_y == out_dst_y));
    p_flip_at_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_inject && in_mid_x == cur_x && in_mid_y == cur_y) |=> out_phase);
    p_phase_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_inject && in_phase) |=> out_phase);
    p_mid_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_inject) |=>
        (out_mid_x == $past(in_mid_x) && out_mid_y == $past(in_mid_y)));
    p_port_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_port) == 1);
    p_local_at_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port[0]) |->
        (out_phase && out_dst_x == $past(cur_x) && out_dst_y == $past(cur_y)));
    p_idle_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_port == 5'd0);
endmodule

bind valiant_route valiant_route_chk #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inject(in_inject),
    .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_mid_x(in_mid_x), .in_mid_y(in_mid_y),
    .in_phase(in_phase), .cur_x(cur_x), .cur_y(cur_y), .quad_mode(quad_mode),
    .gate_mode(gate_mode), .high_load(high_load), .out_valid(out_valid),
    .out_port(out_port), .out_dst_x(out_dst_x), .out_dst_y(out_dst_y),
    .out_mid_x(out_mid_x), .out_mid_y(out_mid_y), .out_phase(out_phase)
);

// File: tb/valiant_route_bench.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module valiant_route_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MX = 5;
    localparam int MY = 3;
    localparam int XW = 3;
    localparam int YW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_inject = 1'b0, in_phase = 1'b0;
    logic [XW-1:0] in_dst_x = '0, in_mid_x = '0, cur_x = '0;
    logic [YW-1:0] in_dst_y = '0, in_mid_y = '0, cur_y = '0;
    logic          quad_mode = 1'b0, gate_mode = 1'b0, high_load = 1'b0;
    logic          out_valid, out_phase;
    logic [4:0]    out_port;
    logic [XW-1:0] out_dst_x, out_mid_x;
    logic [YW-1:0] out_dst_y, out_mid_y;

    int n_checks = 0;
    int n_errors = 0;

    // Pending expectation for the next falling edge.
    bit       e_valid = 0;
    bit [4:0] e_port = 0;
    int       e_dx, e_dy, e_mx, e_my;
    bit       e_ph;
    string    e_tag = "R9";

    logic [15:0] mdl_rnd;

    valiant_route #(.MESH_X(MX), .MESH_Y(MY)) u_valiant_route (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inject(in_inject),
        .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_mid_x(in_mid_x), .in_mid_y(in_mid_y),
        .in_phase(in_phase), .cur_x(cur_x), .cur_y(cur_y), .quad_mode(quad_mode),
        .gate_mode(gate_mode), .high_load(high_load), .out_valid(out_valid),
        .out_port(out_port), .out_dst_x(out_dst_x), .out_dst_y(out_dst_y),
        .out_mid_x(out_mid_x), .out_mid_y(out_mid_y), .out_phase(out_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference generator per R2.
    always @(posedge clk) begin
        if (!rst_n) mdl_rnd <= 16'hACE1;
        else mdl_rnd <= {mdl_rnd[14:0], mdl_rnd[15] ^ mdl_rnd[13] ^ mdl_rnd[12] ^ mdl_rnd[10]};
    end

    task automatic check_out();
        bit ok;
        n_checks++;
        ok = (out_valid == e_valid) && (out_port == e_port);
        if (e_valid)
            ok = ok && int'(out_dst_x) == e_dx && int'(out_dst_y) == e_dy &&
                 int'(out_mid_x) == e_mx && int'(out_mid_y) == e_my && out_phase == e_ph;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual v=%0b port=%05b dst=(%0d,%0d) mid=(%0d,%0d) ph=%0b expected v=%0b port=%05b dst=(%0d,%0d) mid=(%0d,%0d) ph=%0b",
                     e_tag, out_valid, out_port, out_dst_x, out_dst_y, out_mid_x, out_mid_y, out_phase,
                     e_valid, e_port, e_dx, e_dy, e_mx, e_my, e_ph);
        end
    endtask

    // Check the previous result, then present a new header and record its expectation.
    task automatic drive(input bit v, input bit inj, input int dx, input int dy,
                         input int mx, input int my, input bit ph, input int cx, input int cy,
                         input bit q, input bit g, input bit hl, input string tag);
        int m_x, m_y, tx, ty, rx, ry;
        bit p;
        @(negedge clk);
        check_out();
        e_tag = tag;
        e_valid = v;
        e_port = 0;
        if (v) begin
            if (inj) begin
                if (g && !hl) begin
                    m_x = dx; m_y = dy; p = 1;
                end else begin
                    rx = int'(mdl_rnd[7:0]);
                    ry = int'(mdl_rnd[15:8]);
                    if (q) begin
                        m_x = (dx < MX/2) ? rx % (MX/2) : MX/2 + rx % (MX - MX/2);
                        m_y = (dy < MY/2) ? ry % (MY/2) : MY/2 + ry % (MY - MY/2);
                    end else begin
                        m_x = rx % MX; m_y = ry % MY;
                    end
                    p = 0;
                end
            end else begin
                m_x = mx; m_y = my; p = ph;
            end
            if (!p && cx == m_x && cy == m_y) p = 1;
            tx = p ? dx : m_x;
            ty = p ? dy : m_y;
            if (tx > cx)      e_port = 5'b00100;
            else if (tx < cx) e_port = 5'b10000;
            else if (ty > cy) e_port = 5'b00010;
            else if (ty < cy) e_port = 5'b01000;
            else              e_port = 5'b00001;
            e_dx = dx; e_dy = dy; e_mx = m_x; e_my = m_y; e_ph = p;
        end
        in_valid = v; in_inject = inj; in_phase = ph;
        in_dst_x = XW'(dx); in_dst_y = YW'(dy);
        in_mid_x = XW'(mx); in_mid_y = YW'(my);
        cur_x = XW'(cx); cur_y = YW'(cy);
        quad_mode = q; gate_mode = g; high_load = hl;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_errors++;
        $display("FAIL R1: watchdog expired, actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        n_checks++;
        if (out_valid !== 1'b0 || out_port !== 5'd0 || out_phase !== 1'b0 ||
            out_mid_x !== '0 || out_mid_y !== '0) begin
            n_errors++;
            $display("FAIL R9: actual v=%0b port=%05b ph=%0b expected all zero", out_valid, out_port, out_phase);
        end
        rst_n = 1'b1;
        e_valid = 0; e_port = 0; e_tag = "R10";
        // R7 transit routing in each direction
        drive(1, 0, 3, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R7 east");
        drive(1, 0, 3, 0, 0, 0, 1, 3, 2, 0, 0, 0, "R7 south");
        drive(1, 0, 3, 2, 0, 0, 1, 3, 0, 0, 0, 0, "R7 north");
        drive(1, 0, 0, 2, 0, 0, 1, 4, 0, 0, 0, 0, "R7 west");
        // R8 arrival
        drive(1, 0, 2, 1, 4, 2, 1, 2, 1, 0, 0, 0, "R8 local");
        // R5 flip at intermediate
        drive(1, 0, 0, 0, 2, 2, 0, 2, 2, 0, 0, 0, "R5 flip");
        // R6 phase-0 packet at destination still heads to intermediate
        drive(1, 0, 0, 1, 4, 1, 0, 0, 1, 0, 0, 0, "R6 toward mid");
        // R10 idle
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        // R2 injections without options
        for (int i = 0; i < 6; i++)
            drive(1, 1, i % MX, i % MY, 0, 0, 1, (i + 2) % MX, 1, 0, 0, 0, "R2 inject");
        // R3 quadrant restriction on both halves
        for (int i = 0; i < 8; i++)
            drive(1, 1, (i * 3) % MX, i % MY, 0, 0, 0, 2, (i + 1) % MY, 1, 0, 1, "R3 quadrant");
        // R4 load gating
        drive(1, 1, 4, 2, 1, 1, 0, 0, 0, 0, 1, 0, "R4 gated minimal");
        drive(1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 1, 0, "R4 gated at dst");
        drive(1, 1, 4, 2, 1, 1, 0, 0, 0, 0, 1, 1, "R4 high load detour");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 gap");
        // R5 injection landing on source: scan sources until the draw matches
        for (int i = 0; i < 40; i++)
            drive(1, 1, 0, 0, 0, 0, 0, i % MX, (i / MX) % MY, 0, 0, 0, "R5 inject at source");
        // Mixed random traffic
        for (int i = 0; i < 600; i++)
            drive($urandom_range(1) == 1 || i % 7 != 0, $urandom_range(1) == 1,
                  $urandom_range(MX - 1), $urandom_range(MY - 1),
                  $urandom_range(MX - 1), $urandom_range(MY - 1), $urandom_range(1) == 1,
                  $urandom_range(MX - 1), $urandom_range(MY - 1),
                  $urandom_range(1) == 1, $urandom_range(1) == 1, $urandom_range(1) == 1,
                  "R1 R7 random");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 drain");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 drain");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule